// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's complement operands of a configurable width and returns the full double-width signed product. It works serially. One start pulse loads the operands. After that, the block makes one radix-2 Booth step per clock. Each step looks at the lowest multiplier bit together with the bit shifted out in the previous step. From that pair it adds the multiplicand to the running partial product, subtracts it, or leaves the partial product alone. It then shifts the whole accumulator, multiplier and history chain one place to the right, copying the sign bit.

After as many steps as the operand has bits, the block raises a one-cycle completion pulse. The product then stays on the output until the next accepted start. Because of the arithmetic shift, signed operands need no correction step. The accumulator carries one guard bit, so the most negative operand value is handled without overflow. A caller raises start for one cycle while the block is idle, waits for the done pulse, and reads the product.

Top module: `booth_seq_mul`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it is released, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while idle loads the operands, and `busy` is 1 from the next cycle on. Exactly WIDTH clock edges later, `done` is 1.
- R3: When `done` is 1, `product` (2*WIDTH bits, two's complement) equals the signed product of `multiplicand` and `multiplier` as they were sampled with the accepted `start`. For example, with WIDTH=8, 0xFB times 0xFD gives 0x000F (+15), not the unsigned value.
- R4: `done` is high for exactly one cycle per operation, and `busy` is 0 in that cycle.
- R5: After `done`, `product` holds its value in every idle cycle until the next accepted `start`, whatever the operand inputs do.
- R6: A `start` raised while `busy` is 1 is ignored. The running operation keeps its operands and its completion time, and no extra operation follows.
- R7: The operands at the extremes, -2^(WIDTH-1) and 2^(WIDTH-1)-1, produce the correct product in every combination. This includes -2^(WIDTH-1) times -2^(WIDTH-1), which equals +2^(2*WIDTH-2).
- R8: Raising `rst` in the middle of an operation returns the block to idle. `busy`, `done` and `product` read 0, and no `done` follows for that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch request, honoured only while idle |
| multiplicand | input | WIDTH | Signed multiplicand, sampled with an accepted start |
| multiplier | input | WIDTH | Signed multiplier, sampled with an accepted start |
| busy | output | 1 | High while Booth steps are in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Signed double-width product |

## Verification
The bench builds the block with the default WIDTH of 8. At this width, every extreme-operand combination and every sign mix can be driven directly. Several hundred random operand pairs cover all four Booth step choices, including long runs of ones and zeros. Only 8 steps per operation keep the bench short, so it also checks the exact completion latency of every operation, a mid-run start that must be ignored, and a reset issued partway through a run.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Control state: waiting for a launch, or stepping.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctlState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;  // capture operands, clear accumulator and history bit
    logic step;  // one Booth decision followed by one arithmetic shift
  } dpStrobe_t;

endpackage

// File: rtl/booth_mul_ctrl.sv
module booth_mul_ctrl
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = $clog2(WIDTH + 1);

  ctlState_t        state;
  logic [CNT_W-1:0] stepsLeft;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      stepsLeft <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_RUN;
            stepsLeft <= CNT_W'(WIDTH);
          end
        end
        ST_RUN: begin
          stepsLeft <= stepsLeft - 1'b1;
          if (stepsLeft == CNT_W'(1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
    busy        = (state == ST_RUN);
  end

endmodule

// File: rtl/booth_mul_dpath.sv
module booth_mul_dpath
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          strobe,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);

  // One guard bit above the operand width keeps acc - (-2^(W-1)) in range.
  localparam int ACC_W = WIDTH + 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] mcand;
  logic [WIDTH-1:0] mplier;
  logic             histBit;
  logic [ACC_W-1:0] accNext;

  // Booth decision on the pair {current LSB, previous LSB}.
  always_comb begin
    unique case ({mplier[0], histBit})
      2'b10:   accNext = acc - mcand;
      2'b01:   accNext = acc + mcand;
      default: accNext = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      mcand   <= '0;
      mplier  <= '0;
      histBit <= 1'b0;
    end else if (strobe.load) begin
      acc     <= '0;
      mcand   <= {multiplicand[WIDTH-1], multiplicand};
      mplier  <= multiplier;
      histBit <= 1'b0;
    end else if (strobe.step) begin
      // Arithmetic right shift across accumulator, multiplier and history.
      acc     <= {accNext[ACC_W-1], accNext[ACC_W-1:1]};
      mplier  <= {accNext[0], mplier[WIDTH-1:1]};
      histBit <= mplier[0];
    end
  end

  assign product = {acc[WIDTH-1:0], mplier};

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  dpStrobe_t strobe;

  booth_mul_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  booth_mul_dpath #(.WIDTH(WIDTH)) uDpath (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  // R2: an idle launch makes the block busy on the next cycle.
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  // R4: the completion pulse lasts one cycle.
  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: done and busy are never high together.
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5: an idle cycle without a launch leaves the product unchanged.
  a_r5_product_stable: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));

  // R6: a run ends only through the completion pulse.
  a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R6: done only follows a busy cycle.
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

endmodule

bind booth_seq_mul booth_mul_chk #(.WIDTH(WIDTH)) uChk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/tb_booth_seq_mul.sv
module tb_booth_seq_mul;

  localparam int W = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mcandIn = '0;
  logic [W-1:0]  mplierIn = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  booth_seq_mul #(.WIDTH(W)) dut (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (mcandIn),
    .multiplier   (mplierIn),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  // Low 2W bits of the product of sign-extended operands = signed product.
  function automatic logic [PW-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] ea, eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return ea * eb;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Present operands with start for one cycle; returns after the accept edge.
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    mcandIn  = a;
    mplierIn = b;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  // Count negedges until done is seen.
  task automatic waitDone(output int cyc);
    cyc = 0;
    while (!done && cyc < W + 6) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic runVector(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    int cyc;
    logic [PW-1:0] exp;
    exp = refMul(a, b);
    launch(a, b);
    chk(busy === 1'b1, "R2 busy after start", longint'(busy), 1);
    waitDone(cyc);
    chk(cyc == W, "R2 latency", cyc, W);
    chk(product === exp, tag, longint'(product), longint'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [PW-1:0] held;
    logic [PW-1:0] exp;
    void'($urandom(32'd20240917));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {busy, done}, 0);
    chk(product === '0, "R1 product in reset", longint'(product), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1 after release",
        longint'(product), 0);

    // R3: directed sign mixes
    runVector(8'd7, 8'd3, "R3 7*3");
    runVector(8'hFB, 8'hFD, "R3 signed not unsigned");
    runVector(8'd0, 8'h9C, "R3 zero operand");
    runVector(8'hFF, 8'hFF, "R3 -1*-1");
    runVector(8'h55, 8'hAA, "R3 alternating bits");

    // R4: done for one cycle, not busy
    runVector(8'd12, 8'hF3, "R3 12*-13");
    chk(busy === 1'b0, "R4 busy low with done", longint'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R4 done one cycle", longint'(done), 0);

    // R5: product held while idle, operand inputs moving
    held = product;
    for (int i = 0; i < 6; i++) begin
      mcandIn  = W'($urandom);
      mplierIn = W'($urandom);
      @(negedge clk);
    end
    chk(product === held && done === 1'b0, "R5 product held", longint'(product), longint'(held));

    // R7: extremes
    runVector(8'h80, 8'h80, "R7 min*min");
    runVector(8'h80, 8'h7F, "R7 min*max");
    runVector(8'h7F, 8'h80, "R7 max*min");
    runVector(8'h7F, 8'h7F, "R7 max*max");
    runVector(8'h80, 8'hFF, "R7 min*-1");
    runVector(8'hFF, 8'h80, "R7 -1*min");
    runVector(8'h80, 8'h01, "R7 min*1");

    // R6: start while busy is ignored
    exp = refMul(8'h93, 8'h2D);
    launch(8'h93, 8'h2D);
    mcandIn  = 8'h11;
    mplierIn = 8'h22;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    waitDone(cyc);
    chk(cyc == W - 1, "R6 completion time kept", cyc, W - 1);
    chk(product === exp, "R6 operands kept", longint'(product), longint'(exp));
    repeat (W + 2) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R6 no extra run", {busy, done}, 0);

    // R8: reset in the middle of a run
    launch(8'h6B, 8'hC4);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R8 abort state",
        longint'(product), 0);
    cyc = 0;
    for (int i = 0; i < W + 3; i++) begin
      @(negedge clk);
      if (done || busy) cyc++;
    end
    chk(cyc == 0, "R8 no done after abort", cyc, 0);

    // R3: random operands
    for (int i = 0; i < 400; i++) begin
      runVector(W'($urandom), W'($urandom), "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule